// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Hazard Controller

This block is the sequencing logic for an in-order pipeline of six stages: instruction fetch (FI), decode (DI), operand-address calculation (CO), operand fetch (FO), execute (EI) and operand write-back (WO). It takes one instruction descriptor per cycle from the fetch side. A descriptor carries a valid bit, a tag, a destination register, two source registers, a branch flag, a taken flag and a branch target. The block records which descriptor sits in each stage and advances the pipe by one stage per cycle. It publishes the valid bit and tag of every stage, so datapath slices can follow it.

Two hazards change the flow. The first is a read-after-write dependency. An instruction in FO that reads a register still being produced by an older instruction in EI or WO holds the front four stages, and the block sends a bubble into EI until the producer has left WO. The second is a taken branch. When a taken branch reaches EI, the block asserts flush and redirect with the branch target, and the four younger stages are emptied at the next edge. The `stall` output also serves as the fetch side's hold signal. A descriptor offered while `stall` or `flush` is high is not taken. A stalled descriptor must be offered again.

Top module: `pipe6_hazard_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every stage valid bit and the stall, flush, redirect and retire outputs are low.
- R2: A descriptor offered in a cycle with stall and flush low is in FI after the next edge and moves one stage per edge. N back-to-back independent descriptors, the first offered in cycle c, retire with the last retire pulse in cycle c+N+5.
- R3: Stall is high exactly while FO holds a valid instruction and one of its nonzero source registers equals the destination of a valid instruction in EI or WO, unless flush is high. A descriptor offered while stall is high is not taken.
- R4: On each edge at which stall is high, FI, DI, CO and FO keep their valid bits and tags, EI becomes empty, and the EI content moves to WO.
- R5: Register 0 never causes a stall, whether it appears as a source or as a producer's destination.
- R6: When EI holds a valid taken branch, flush and redirect are high in that cycle and redirect_tgt equals the branch target. After the next edge FI to FO are empty, the branch is in WO, and the descriptor offered during the flush cycle is discarded.
- R7: A branch whose taken flag is low causes no flush, and every descriptor behind it retires in order.
- R8: When flush and a dependency occur in the same cycle, flush takes precedence and stall stays low.
- R9: Retire is high for exactly one cycle per valid instruction in WO. retire_tag carries that instruction's tag, and instructions retire in the order they were accepted.
- R10: A consumer that directly follows its producer stalls for 2 cycles. A consumer with one independent instruction between them stalls for 1 cycle. A consumer with two or more instructions between them does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered this cycle |
| in_tag | input | TAG_W | Tag that identifies the descriptor |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_is_br | input | 1 | Descriptor is a conditional branch |
| in_br_taken | input | 1 | Branch outcome, taken when high |
| in_br_tgt | input | ADDR_W | Branch target address |
| stg_valid | output | 6 | Per-stage occupancy, bit 0 = FI through bit 5 = WO |
| stg_tag | output | 6*TAG_W | Per-stage tags, stage s at bits [s*TAG_W +: TAG_W] |
| stall | output | 1 | Front four stages hold and fetch must re-offer |
| flush | output | 1 | Younger stages are being emptied |
| redirect | output | 1 | Fetch must restart at redirect_tgt |
| redirect_tgt | output | ADDR_W | Restart address, zero when no redirect |
| retire | output | 1 | A valid instruction is in WO this cycle |
| retire_tag | output | TAG_W | Tag of the retiring instruction, zero otherwise |

## Verification
The bound checker examines several properties on every cycle: that the front stages are frozen and EI gets a bubble after each stall, that the front is emptied after a flush while the branch moves on to WO, that an accepted descriptor appears in FI, and that EI content always reaches WO and retire. The bench's streams cover the properties that hold over a whole run. These are the N+5 completion time, the exact stall count for each producer–consumer distance, immunity of register 0, the in-order retire sequence, the discarding of the descriptor offered during a flush, and the precedence of flush over a coincident dependency.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;

   localparam int P6_NSTAGE = 6;

   // stage indices, oldest last; the hazard and branch logic depend on this order
   localparam int P6_FI = 0;
   localparam int P6_DI = 1;
   localparam int P6_CO = 2;
   localparam int P6_FO = 3;
   localparam int P6_EI = 4;
   localparam int P6_WO = 5;

   // number of older stages searched for a pending write
   localparam int P6_N_OLDER = P6_WO - P6_FO;

   typedef enum logic [1:0] {
      ADV_SHIFT = 2'd0,
      ADV_STALL = 2'd1,
      ADV_FLUSH = 2'd2
   } p6_adv_e;

endpackage

// File: rtl/p6_hazard_unit.sv
module p6_hazard_unit #(
   parameter int REG_W   = 5,
   parameter int N_OLDER = 2
) (
   input  logic                             fo_valid,
   input  logic [REG_W-1:0]                 fo_src_a,
   input  logic [REG_W-1:0]                 fo_src_b,
   input  logic [N_OLDER-1:0]               old_valid,
   input  logic [N_OLDER-1:0][REG_W-1:0]    old_dst,
   output logic                             raw_hit
);

   localparam logic [REG_W-1:0] ZERO_REG = '0;

   logic               a_live;
   logic               b_live;
   logic [N_OLDER-1:0] lane_hit;

   // register 0 is never a pending result
   assign a_live = fo_valid && (fo_src_a != ZERO_REG);
   assign b_live = fo_valid && (fo_src_b != ZERO_REG);

   generate
      for (genvar g = 0; g < N_OLDER; g++) begin : g_lane
         logic match_a;
         logic match_b;
         assign match_a     = a_live && (old_dst[g] == fo_src_a);
         assign match_b     = b_live && (old_dst[g] == fo_src_b);
         assign lane_hit[g] = old_valid[g] && (match_a || match_b);
      end
   endgenerate

   assign raw_hit = |lane_hit;

endmodule

// File: rtl/p6_flow_ctrl.sv
module p6_flow_ctrl
   import pipe6_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              ei_valid,
   input  logic              ei_is_br,
   input  logic              ei_taken,
   input  logic [ADDR_W-1:0] ei_tgt,
   input  logic              raw_hit,
   output logic              flush_o,
   output logic              stall_o,
   output logic [ADDR_W-1:0] tgt_o,
   output p6_adv_e           adv_o
);

   // branches resolve in EI; a taken one outranks any dependency in FO
   assign flush_o = ei_valid && ei_is_br && ei_taken;
   assign stall_o = raw_hit && !flush_o;
   assign tgt_o   = flush_o ? ei_tgt : '0;

   always_comb begin
      if (flush_o)      adv_o = ADV_FLUSH;
      else if (stall_o) adv_o = ADV_STALL;
      else              adv_o = ADV_SHIFT;
   end

endmodule

// File: rtl/p6_stage_regs.sv
module p6_stage_regs
   import pipe6_pkg::*;
#(
   parameter int PW = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  p6_adv_e                           adv,
   input  logic                              in_valid,
   input  logic [PW-1:0]                     in_word,
   output logic [P6_NSTAGE-1:0]              q_valid,
   output logic [P6_NSTAGE-1:0][PW-1:0]      q_word
);

   logic [P6_NSTAGE-1:0]          feed_valid;
   logic [P6_NSTAGE-1:0][PW-1:0]  feed_word;

   assign feed_valid = {q_valid[P6_NSTAGE-2:0], in_valid};
   assign feed_word  = {q_word[P6_NSTAGE-2:0], in_word};

   generate
      for (genvar s = 0; s < P6_NSTAGE; s++) begin : g_stg
         localparam bit FRONT  = (s <= P6_FO);
         localparam bit BUBBLE = (s == P6_EI);
         localparam bit BACK   = (s > P6_EI);

         logic          v_r;
         logic [PW-1:0] w_r;
         logic          nxt_v;
         logic          take;

         always_comb begin
            unique case (adv)
               ADV_STALL: begin
                  take  = BACK;
                  nxt_v = FRONT ? v_r : (BACK ? feed_valid[s] : 1'b0);
               end
               ADV_FLUSH: begin
                  take  = BACK;
                  nxt_v = BACK ? feed_valid[s] : 1'b0;
               end
               default: begin
                  take  = 1'b1;
                  nxt_v = feed_valid[s];
               end
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_r <= 1'b0;
               w_r <= '0;
            end else begin
               v_r <= nxt_v;
               if (take) w_r <= feed_word[s];
            end
         end

         assign q_valid[s] = v_r;
         assign q_word[s]  = w_r;
      end
   endgenerate

endmodule

// File: rtl/pipe6_hazard_ctrl.sv
module pipe6_hazard_ctrl
   import pipe6_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [TAG_W-1:0]              in_tag,
   input  logic [REG_W-1:0]              in_dst,
   input  logic [REG_W-1:0]              in_src_a,
   input  logic [REG_W-1:0]              in_src_b,
   input  logic                          in_is_br,
   input  logic                          in_br_taken,
   input  logic [ADDR_W-1:0]             in_br_tgt,
   output logic [P6_NSTAGE-1:0]          stg_valid,
   output logic [P6_NSTAGE*TAG_W-1:0]    stg_tag,
   output logic                          stall,
   output logic                          flush,
   output logic                          redirect,
   output logic [ADDR_W-1:0]             redirect_tgt,
   output logic                          retire,
   output logic [TAG_W-1:0]              retire_tag
);

   // payload field offsets inside one stage word
   localparam int OFF_TGT = 0;
   localparam int OFF_TK  = OFF_TGT + ADDR_W;
   localparam int OFF_BR  = OFF_TK + 1;
   localparam int OFF_SB  = OFF_BR + 1;
   localparam int OFF_SA  = OFF_SB + REG_W;
   localparam int OFF_DST = OFF_SA + REG_W;
   localparam int OFF_TAG = OFF_DST + REG_W;
   localparam int PW      = OFF_TAG + TAG_W;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("REG_W must lie in 1..8");
      end
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ADDR_W must lie in 1..64");
      end
      if (TAG_W < 1 || TAG_W > 32) begin : g_bad_tag_w
         $error("TAG_W must lie in 1..32");
      end
      if (P6_N_OLDER != 2) begin : g_bad_depth
         $error("hazard window must cover EI and WO");
      end
   endgenerate

   logic [PW-1:0]                         in_word;
   logic [P6_NSTAGE-1:0]                  st_valid;
   logic [P6_NSTAGE-1:0][PW-1:0]          st_word;
   logic [P6_N_OLDER-1:0]                 old_valid;
   logic [P6_N_OLDER-1:0][REG_W-1:0]      old_dst;
   logic                                  raw_hit;
   logic                                  flush_w;
   logic                                  stall_w;
   logic [ADDR_W-1:0]                     tgt_w;
   p6_adv_e                               adv;

   assign in_word = {in_tag, in_dst, in_src_a, in_src_b, in_is_br, in_br_taken, in_br_tgt};

   p6_stage_regs #(.PW(PW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .in_valid (in_valid),
      .in_word  (in_word),
      .q_valid  (st_valid),
      .q_word   (st_word)
   );

   generate
      for (genvar k = 0; k < P6_N_OLDER; k++) begin : g_older
         assign old_valid[k] = st_valid[P6_EI + k];
         assign old_dst[k]   = st_word[P6_EI + k][OFF_DST +: REG_W];
      end
   endgenerate

   p6_hazard_unit #(.REG_W(REG_W), .N_OLDER(P6_N_OLDER)) u_haz (
      .fo_valid  (st_valid[P6_FO]),
      .fo_src_a  (st_word[P6_FO][OFF_SA +: REG_W]),
      .fo_src_b  (st_word[P6_FO][OFF_SB +: REG_W]),
      .old_valid (old_valid),
      .old_dst   (old_dst),
      .raw_hit   (raw_hit)
   );

   p6_flow_ctrl #(.ADDR_W(ADDR_W)) u_flow (
      .ei_valid (st_valid[P6_EI]),
      .ei_is_br (st_word[P6_EI][OFF_BR]),
      .ei_taken (st_word[P6_EI][OFF_TK]),
      .ei_tgt   (st_word[P6_EI][OFF_TGT +: ADDR_W]),
      .raw_hit  (raw_hit),
      .flush_o  (flush_w),
      .stall_o  (stall_w),
      .tgt_o    (tgt_w),
      .adv_o    (adv)
   );

   generate
      for (genvar s = 0; s < P6_NSTAGE; s++) begin : g_tag_out
         assign stg_tag[s*TAG_W +: TAG_W] = st_word[s][OFF_TAG +: TAG_W];
      end
   endgenerate

   assign stg_valid    = st_valid;
   assign stall        = stall_w;
   assign flush        = flush_w;
   assign redirect     = flush_w;
   assign redirect_tgt = tgt_w;
   assign retire       = st_valid[P6_WO];
   assign retire_tag   = st_valid[P6_WO] ? st_word[P6_WO][OFF_TAG +: TAG_W] : '0;

endmodule

// File: rtl/p6_checker.sv
module p6_checker #(
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [TAG_W-1:0]     in_tag,
   input logic [5:0]           stg_valid,
   input logic [6*TAG_W-1:0]   stg_tag,
   input logic                 stall,
   input logic                 flush,
   input logic                 retire,
   input logic [TAG_W-1:0]     retire_tag
);

   localparam int FRONT_W = 4 * TAG_W;

   logic [TAG_W-1:0] ei_tag;
   logic [TAG_W-1:0] wo_tag;
   logic [TAG_W-1:0] fi_tag;

   assign ei_tag = stg_tag[4*TAG_W +: TAG_W];
   assign wo_tag = stg_tag[5*TAG_W +: TAG_W];
   assign fi_tag = stg_tag[0 +: TAG_W];

   p_stall_front_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(stg_valid[3:0]) && $stable(stg_tag[FRONT_W-1:0])));

   p_stall_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stg_valid[4]);

   p_stall_needs_fo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> stg_valid[3]);

   p_flush_clears_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (stg_valid[3:0] == 4'b0000));

   p_flush_keeps_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (stg_valid[5] && (wo_tag == $past(ei_tag))));

   p_accept_enters_fi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stall && !flush) |=> (stg_valid[0] && (fi_tag == $past(in_tag))));

   p_ei_reaches_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stg_valid[4] |=> (retire && (retire_tag == $past(ei_tag))));

   p_empty_ei_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_valid[4] |=> !retire);

endmodule

bind pipe6_hazard_ctrl p6_checker #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_p6_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_tag     (in_tag),
   .stg_valid  (stg_valid),
   .stg_tag    (stg_tag),
   .stall      (stall),
   .flush      (flush),
   .retire     (retire),
   .retire_tag (retire_tag)
);

// File: tb/pipe6_hazard_ctrl_bench.sv
module pipe6_hazard_ctrl_bench;

   localparam int RW = 5;
   localparam int AW = 16;
   localparam int TW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid;
   logic [TW-1:0]     in_tag;
   logic [RW-1:0]     in_dst, in_src_a, in_src_b;
   logic              in_is_br, in_br_taken;
   logic [AW-1:0]     in_br_tgt;
   logic [5:0]        stg_valid;
   logic [6*TW-1:0]   stg_tag;
   logic              stall, flush, redirect, retire;
   logic [AW-1:0]     redirect_tgt;
   logic [TW-1:0]     retire_tag;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   int s_dst [16];
   int s_sa  [16];
   int s_sb  [16];

   pipe6_hazard_ctrl #(.REG_W(RW), .ADDR_W(AW), .TAG_W(TW)) u_pipe6_hazard_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_dst(in_dst),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_is_br(in_is_br),
      .in_br_taken(in_br_taken), .in_br_tgt(in_br_tgt), .stg_valid(stg_valid),
      .stg_tag(stg_tag), .stall(stall), .flush(flush), .redirect(redirect),
      .redirect_tgt(redirect_tgt), .retire(retire), .retire_tag(retire_tag));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      in_valid = 0; in_tag = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
      in_is_br = 0; in_br_taken = 0; in_br_tgt = '0;
   endtask

   task automatic offer(input int tag, input int d, input int a, input int b,
                        input bit br, input bit tk, input int tgt);
      in_valid = 1; in_tag = TW'(tag); in_dst = RW'(d); in_src_a = RW'(a);
      in_src_b = RW'(b); in_is_br = br; in_br_taken = tk; in_br_tgt = AW'(tgt);
   endtask

   // independent program: dst = index+1, sources read never-written registers
   task automatic plain_prog(input int n);
      for (int i = 0; i < n; i++) begin
         s_dst[i] = i + 1; s_sa[i] = 20; s_sb[i] = 21;
      end
   endtask

   task automatic run_stream(input int n, input int exp_stalls, input string req);
      int i, start, last_ret, nret, nstall;
      bit order_ok, hold_ok, prev_stall;
      logic [TW-1:0] prev_fo;
      i = 0; nret = 0; nstall = 0; last_ret = -1;
      order_ok = 1; hold_ok = 1; prev_stall = 0; prev_fo = '0;
      @(negedge clk);
      start = cyc;
      for (int k = 0; k < n + 30; k++) begin
         if (retire) begin
            if (int'(retire_tag) != nret) order_ok = 0;
            nret++;
            last_ret = cyc;
         end
         // R4: after a stalled edge EI is empty and FO kept its tag
         if (prev_stall && (stg_valid[4] || stg_tag[3*TW +: TW] != prev_fo)) hold_ok = 0;
         prev_stall = stall;
         prev_fo = stg_tag[3*TW +: TW];
         if (stall) nstall++;
         if (i < n) offer(i, s_dst[i], s_sa[i], s_sb[i], 0, 0, 0);
         else idle();
         if (i < n && !stall) i++;
         @(negedge clk);
      end
      idle();
      chk(nret == n, {req, " R9 retire count"}, nret, n);
      chk(order_ok, {req, " R9 retire order"}, order_ok, 1);
      chk(nstall == exp_stalls, {req, " R3/R10 stall cycles"}, nstall, exp_stalls);
      chk(last_ret - start == n + 5 + exp_stalls, {req, " R2 completion cycle"},
          last_ret - start, n + 5 + exp_stalls);
      chk(hold_ok, {req, " R4 hold and bubble"}, hold_ok, 1);
   endtask

   task automatic branch_test(input bit tk);
      int rets [16];
      int nret, nflush, flush_k, stall_at5;
      bit tgt_ok, front_ok;
      nret = 0; nflush = 0; flush_k = -1; stall_at5 = 0; tgt_ok = 1; front_ok = 1;
      @(negedge clk);
      for (int k = 0; k < 20; k++) begin
         if (retire && nret < 16) begin rets[nret] = int'(retire_tag); nret++; end
         if (flush) begin
            nflush++; flush_k = k;
            if (!redirect || redirect_tgt != 16'hBEEF) tgt_ok = 0;
         end
         if (k == 5) stall_at5 = stall;
         if (k == 6 && tk)
            if (stg_valid[3:0] != 4'b0 || !stg_valid[5] || stg_tag[5*TW +: TW] != 8'd50)
               front_ok = 0;
         if (k == 0) offer(50, 7, 20, 21, 1, tk, 16'hBEEF);
         else if (k <= 8) offer(50 + k, 10 + k, (k == 1 && tk) ? 7 : 20, 21, 0, 0, 0);
         else idle();
         @(negedge clk);
      end
      idle();
      if (tk) begin
         chk(nflush == 1 && flush_k == 5, "R6 single flush with branch in EI", flush_k, 5);
         chk(tgt_ok, "R6 redirect target", tgt_ok, 1);
         chk(front_ok, "R6 front emptied and branch in WO", front_ok, 1);
         chk(stall_at5 == 0, "R8 flush outranks dependency", stall_at5, 0);
         chk(nret == 4, "R6 retire count after flush", nret, 4);
         chk(rets[0] == 50 && rets[1] == 56 && rets[2] == 57 && rets[3] == 58,
             "R6 flushed and dropped descriptors absent", rets[1], 56);
      end else begin
         chk(nflush == 0, "R7 no flush when not taken", nflush, 0);
         chk(nret == 9, "R7 retire count", nret, 9);
         for (int j = 0; j < 9 && j < nret; j++)
            chk(rets[j] == 50 + j, "R7 retire order", rets[j], 50 + j);
      end
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      chk(stg_valid == 6'b0, "R1 stages empty in reset", int'(stg_valid), 0);
      chk(!stall && !flush && !redirect && !retire, "R1 controls low in reset",
          int'({stall, flush, redirect, retire}), 0);
      rst_n = 1;
      @(negedge clk);
      chk(stg_valid == 6'b0 && !retire, "R1 empty after release", int'(stg_valid), 0);

      // R2: completion time over stream lengths 1..9
      for (int n = 1; n <= 9; n++) begin
         plain_prog(n);
         run_stream(n, 0, "R2 sweep");
      end

      // R10 / R3: producer index 1, consumer 1..3 slots behind, either source
      for (int d = 1; d <= 3; d++) begin
         for (int which = 0; which < 2; which++) begin
            plain_prog(6);
            if (which == 0) s_sa[1 + d] = s_dst[1];
            else            s_sb[1 + d] = s_dst[1];
            run_stream(6, (d < 3) ? 3 - d : 0, "R10 distance");
         end
      end

      // R5: register 0 as producer destination and consumer source
      plain_prog(6);
      s_dst[1] = 0; s_sa[2] = 0; s_sb[2] = 0;
      run_stream(6, 0, "R5 zero register");

      // R3: both sources hit two different producers
      plain_prog(6);
      s_sa[3] = s_dst[2]; s_sb[3] = s_dst[1];
      run_stream(6, 2, "R3 dual source");

      branch_test(1);
      repeat (10) @(negedge clk);
      branch_test(0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule